// File: doc/BRIEF.md
# Two-Phase Page DMA Sequencer

This block moves one page of 512 bytes between a byte-stream flash port and host memory, always passing through an on-chip page buffer. A transfer is done as two phases, and software arms each phase on its own. The internal phase connects the flash port and the buffer. The memory phase connects the buffer and host memory.

For a page read, software first arms the internal phase, which fills the buffer from the flash stream. It then arms the memory phase, which writes the buffer out to memory. For a page write the order is reversed: the memory phase fills the buffer from memory, and the internal phase streams the buffer to the flash side.

Control goes through a small byte-wide register window:
- a settings register (direction and phase select);
- a four-byte host base address;
- an interrupt enable register;
- a write-one-to-clear status register.

Each phase reports its own completion bit. An error response from memory aborts the memory phase and reports an error bit instead.

Top module: `dma2p_seq`

## Requirements
- R1: After reset, every register reads as zero, `irq` is low, and `mem_req`, `fl_in_ready` and `fl_out_valid` are low.
- R2: Settings value 0x03 (bit0 = read direction, bit1 = internal select) starts the flash-to-buffer phase. Byte i is taken from `fl_in_data` on each cycle where `fl_in_valid` and `fl_in_ready` are both high, for i = 0..511. Status bit0 (internal done) is still clear at the first sample after the 512th handshake edge and is set one cycle later.
- R3: Settings value 0x05 (bit2 = memory select, bit0 = read) starts the buffer-to-memory phase. Request i has `mem_we`=1, `mem_addr` = base + i and `mem_wdata` = buffer byte i. After the 512th acknowledged request, status bit1 (memory done) is set one cycle later.
- R4: Settings value 0x04 starts the memory-to-buffer phase. Request i has `mem_we`=0 and `mem_addr` = base + i, and the `mem_rdata` returned on its acknowledge is stored as buffer byte i. Status bit1 is set one cycle after the last acknowledge.
- R5: Settings value 0x02 starts the buffer-to-flash phase. `fl_out_valid` is high and `fl_out_data` equals buffer byte i until a cycle with `fl_out_ready` high. Status bit0 is set one cycle after the 512th handshake.
- R6: A write to the status register (offset 0xC) clears exactly the bits written as one; bits written as zero keep their value.
- R7: `irq` equals the OR over bits 2..0 of (status AND enable), where the enable register is at offset 0x8 and uses the same bit positions as status.
- R8: An acknowledge with `mem_err` high during a memory phase ends the phase at that edge. It sets status bit2 (error), leaves the done bit clear, and drops `mem_req` from the next cycle.
- R9: Writing settings with both phase selects clear stops a running phase with no status change. A value with both selects set starts nothing.
- R10: The host base address is little-endian at offsets 0x4..0x7 (offset 0x4 holds bits 7:0) and reads back as written.
- R11: While a request or stream handshake is waiting, the engine holds its position: `mem_addr`, `mem_wdata` and `fl_out_data` stay the same until the handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| mem_err | input | 1 | Error qualifier on the acknowledge |
| mem_rdata | input | 8 | Memory read data on the acknowledge |
| fl_in_valid | input | 1 | Flash-side byte available |
| fl_in_data | input | 8 | Flash-side incoming byte |
| fl_in_ready | output | 1 | Block accepts a flash-side byte |
| fl_out_valid | output | 1 | Block presents a byte to the flash side |
| fl_out_data | output | 8 | Outgoing flash-side byte |
| fl_out_ready | input | 1 | Flash side takes the outgoing byte |

## Verification
The assertions assume that software does not write the settings or address registers while a handshake is pending on the memory or flash port. They also assume that `mem_ack` is raised only while `mem_req` is high. The stimulus keeps to this. It drives register writes only between phases, or during the stop test while the flash stream is idle. It raises acknowledges only after it has seen a request at the preceding sample point. The stall patterns on each port come from the byte index, so every phase sees both back-to-back and delayed handshakes.

// File: rtl/dma2p_pkg.sv
package dma2p_pkg;

    localparam int          REG_AW   = 4;
    localparam logic [3:0]  OFS_CFG  = 4'h0;
    localparam int          OFS_BASE = 4;
    localparam logic [3:0]  OFS_IEN  = 4'h8;
    localparam logic [3:0]  OFS_STA  = 4'hC;

    // settings: bit2 memory select, bit1 internal select, bit0 read direction
    typedef struct packed {
        logic mem_sel;
        logic int_sel;
        logic rd_dir;
    } cfg_t;

    // status / enable: bit2 error, bit1 memory done, bit0 internal done
    typedef struct packed {
        logic err;
        logic mem_done;
        logic int_done;
    } evt_t;

    typedef enum logic [1:0] {
        MODE_FL_TO_BUF,
        MODE_BUF_TO_FL,
        MODE_BUF_TO_MEM,
        MODE_MEM_TO_BUF
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } eng_st_e;

    function automatic logic cfg_starts(cfg_t c);
        return c.mem_sel ^ c.int_sel;
    endfunction

    function automatic mode_e cfg_mode(cfg_t c);
        if (c.int_sel)
            return c.rd_dir ? MODE_FL_TO_BUF : MODE_BUF_TO_FL;
        return c.rd_dir ? MODE_BUF_TO_MEM : MODE_MEM_TO_BUF;
    endfunction

    function automatic logic mode_is_mem(mode_e m);
        return (m == MODE_BUF_TO_MEM) || (m == MODE_MEM_TO_BUF);
    endfunction

endpackage

// File: rtl/dma2p_page_buf.sv
module dma2p_page_buf #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dma2p_engine.sv
module dma2p_engine
    import dma2p_pkg::*;
#(
    parameter int PAGE_BYTES = 512
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_wr,
    input  cfg_t                          cfg_in,
    input  logic                          fl_in_valid,
    input  logic                          fl_out_ready,
    input  logic                          mem_ack,
    input  logic                          mem_err,
    output mode_e                         mode,
    output logic                          running,
    output logic [$clog2(PAGE_BYTES)-1:0] idx,
    output logic                          xfer,
    output evt_t                          evt
);
    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

    eng_st_e          st_q;
    mode_e            mode_q;
    logic [IDX_W-1:0] idx_q;
    logic             hs;
    logic             abort;
    logic             is_mem;

    assign is_mem  = mode_is_mem(mode_q);
    assign running = (st_q == ST_RUN);

    always_comb begin
        unique case (mode_q)
            MODE_FL_TO_BUF: hs = fl_in_valid;
            MODE_BUF_TO_FL: hs = fl_out_ready;
            default:        hs = mem_ack & ~mem_err;
        endcase
    end

    assign xfer  = running & hs & ~cfg_wr;
    assign abort = running & is_mem & mem_ack & mem_err & ~cfg_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= MODE_FL_TO_BUF;
            idx_q  <= '0;
        end else if (cfg_wr) begin
            idx_q  <= '0;
            mode_q <= cfg_mode(cfg_in);
            st_q   <= cfg_starts(cfg_in) ? ST_RUN : ST_IDLE;
        end else begin
            unique case (st_q)
                ST_RUN: begin
                    if (abort)
                        st_q <= ST_IDLE;
                    else if (xfer) begin
                        if (idx_q == LAST_IDX)
                            st_q <= ST_FIN;
                        else
                            idx_q <= idx_q + 1'b1;
                    end
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        evt          = '0;
        evt.int_done = (st_q == ST_FIN) & ~is_mem & ~cfg_wr;
        evt.mem_done = (st_q == ST_FIN) &  is_mem & ~cfg_wr;
        evt.err      = abort;
    end

    assign mode = mode_q;
    assign idx  = idx_q;
endmodule

// File: rtl/dma2p_regs.sv
module dma2p_regs
    import dma2p_pkg::*;
#(
    parameter int MEM_AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  evt_t              evt,
    output logic              cfg_wr,
    output cfg_t              cfg_q,
    output logic [MEM_AW-1:0] base_q,
    output evt_t              ien_q,
    output evt_t              sta_q,
    output logic [7:0]        rdata,
    output logic              irq
);
    localparam int ABYTES = MEM_AW / 8;

    evt_t clr_mask;

    assign cfg_wr   = reg_we && (reg_addr == OFS_CFG);
    assign clr_mask = (reg_we && (reg_addr == OFS_STA)) ? evt_t'(reg_wdata[2:0]) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            ien_q <= '0;
            sta_q <= '0;
        end else begin
            if (cfg_wr)
                cfg_q <= cfg_t'(reg_wdata[2:0]);
            if (reg_we && (reg_addr == OFS_IEN))
                ien_q <= evt_t'(reg_wdata[2:0]);
            sta_q <= (sta_q & ~clr_mask) | evt;
        end
    end

    for (genvar k = 0; k < ABYTES; k++) begin : g_base
        always_ff @(posedge clk) begin
            if (rst)
                base_q[k*8 +: 8] <= '0;
            else if (reg_we && (reg_addr == REG_AW'(OFS_BASE + k)))
                base_q[k*8 +: 8] <= reg_wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (reg_addr == OFS_CFG)
            rdata = {5'b0, cfg_q};
        else if (reg_addr == OFS_IEN)
            rdata = {5'b0, ien_q};
        else if (reg_addr == OFS_STA)
            rdata = {5'b0, sta_q};
        else begin
            for (int k = 0; k < ABYTES; k++) begin
                if (reg_addr == REG_AW'(OFS_BASE + k))
                    rdata = base_q[k*8 +: 8];
            end
        end
    end

    assign irq = |(sta_q & ien_q);
endmodule

// File: rtl/dma2p_seq.sv
module dma2p_seq
    import dma2p_pkg::*;
#(
    parameter int PAGE_BYTES = 512,
    parameter int MEM_AW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata,
    input  logic              fl_in_valid,
    input  logic [7:0]        fl_in_data,
    output logic              fl_in_ready,
    output logic              fl_out_valid,
    output logic [7:0]        fl_out_data,
    input  logic              fl_out_ready
);
    localparam int IDX_W = $clog2(PAGE_BYTES);

    logic              cfg_wr;
    cfg_t              cfg_q;
    logic [MEM_AW-1:0] base_q;
    evt_t              ien_q;
    evt_t              sta_q;
    evt_t              evt;
    mode_e             mode;
    logic              running;
    logic [IDX_W-1:0]  idx;
    logic              xfer;
    logic              buf_we;
    logic [7:0]        buf_wdata;
    logic [7:0]        buf_rdata;

    dma2p_regs #(.MEM_AW(MEM_AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .evt      (evt),
        .cfg_wr   (cfg_wr),
        .cfg_q    (cfg_q),
        .base_q   (base_q),
        .ien_q    (ien_q),
        .sta_q    (sta_q),
        .rdata    (reg_rdata),
        .irq      (irq)
    );

    dma2p_engine #(.PAGE_BYTES(PAGE_BYTES)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_in      (cfg_t'(reg_wdata[2:0])),
        .fl_in_valid (fl_in_valid),
        .fl_out_ready(fl_out_ready),
        .mem_ack     (mem_ack),
        .mem_err     (mem_err),
        .mode        (mode),
        .running     (running),
        .idx         (idx),
        .xfer        (xfer),
        .evt         (evt)
    );

    assign buf_we    = xfer && ((mode == MODE_FL_TO_BUF) || (mode == MODE_MEM_TO_BUF));
    assign buf_wdata = (mode == MODE_FL_TO_BUF) ? fl_in_data : mem_rdata;

    dma2p_page_buf #(.DEPTH(PAGE_BYTES), .WIDTH(8)) u_buf (
        .clk  (clk),
        .we   (buf_we),
        .waddr(idx),
        .wdata(buf_wdata),
        .raddr(idx),
        .rdata(buf_rdata)
    );

    assign fl_in_ready  = running && (mode == MODE_FL_TO_BUF);
    assign fl_out_valid = running && (mode == MODE_BUF_TO_FL);
    assign fl_out_data  = buf_rdata;
    assign mem_req      = running && mode_is_mem(mode);
    assign mem_we       = (mode == MODE_BUF_TO_MEM);
    assign mem_addr     = base_q + MEM_AW'(idx);
    assign mem_wdata    = buf_rdata;
endmodule

// File: rtl/dma2p_seq_chk.sv
module dma2p_seq_chk #(
    parameter int MEM_AW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [3:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              irq,
    input logic              mem_req,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_ack,
    input logic              mem_err,
    input logic              fl_in_ready,
    input logic              fl_out_valid,
    input logic [2:0]        sta
);
    // R1: ports quiet in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_req && !fl_in_ready && !fl_out_valid && !irq));

    // R2, R3: only one side of the engine is active at a time
    a_r3_one_port_active: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_req, fl_in_ready, fl_out_valid}));

    // R7: a rising interrupt always has a status bit behind it
    a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (sta != 3'b000));

    // R8: an error acknowledge ends the memory phase
    a_r8_err_drops_req: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_err) |=> !mem_req);

    // R9: settings write without a phase select leaves every port idle
    a_r9_stop_idles: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 4'h0 && reg_wdata[2:1] == 2'b00)
        |=> (!mem_req && !fl_in_ready && !fl_out_valid));

    // R11: a waiting memory request keeps its address
    a_r11_req_holds: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !reg_we) |=> (mem_req && $stable(mem_addr)));
endmodule

bind dma2p_seq dma2p_seq_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .irq         (irq),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .fl_in_ready (fl_in_ready),
    .fl_out_valid(fl_out_valid),
    .sta         (sta_q)
);

// File: tb/tb_dma2p_seq.sv
`timescale 1ns/1ps
module tb_dma2p_seq;
    localparam int PAGE = 512;
    localparam logic [31:0] BASE = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        fl_in_valid = 1'b0;
    logic [7:0]  fl_in_data = '0;
    logic        fl_in_ready, fl_out_valid;
    logic [7:0]  fl_out_data;
    logic        fl_out_ready = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dma2p_seq dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .fl_in_valid(fl_in_valid), .fl_in_data(fl_in_data),
        .fl_in_ready(fl_in_ready), .fl_out_valid(fl_out_valid),
        .fl_out_data(fl_out_data), .fl_out_ready(fl_out_ready)
    );

    function automatic logic [7:0] pat_f(int i);
        return 8'((i * 13 + 5) & 255);
    endfunction

    function automatic logic [7:0] pat_g(int i);
        return 8'((i * 29 + 65) & 255);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk_sta(input string req, input logic [7:0] exp);
        logic [7:0] v;
        rd(4'hC, v);
        chk(req, {24'b0, v}, {24'b0, exp});
    endtask

    // flash-to-buffer phase: stall every byte with i%5==2
    task automatic feed_flash(input logic [7:0] sta_before);
        for (int i = 0; i < PAGE; i++) begin
            if (i % 5 == 2) begin
                fl_in_valid = 1'b0;
                @(negedge clk);
            end
            if (i == 0 || i == PAGE - 1) chk("R2 fl_in_ready", {31'b0, fl_in_ready}, 32'd1);
            fl_in_valid = 1'b1;
            fl_in_data  = pat_f(i);
            @(negedge clk);
        end
        fl_in_valid = 1'b0;
        chk_sta("R2 done not yet set", sta_before);
        @(negedge clk);
        chk_sta("R2 internal done one cycle later", sta_before | 8'h01);
    endtask

    // memory phase responder; err_at < 0 means no error
    task automatic serve_mem(input string req, input logic exp_we, input bit use_g,
                             input int err_at, input logic [7:0] sta_before);
        for (int i = 0; i < PAGE; i++) begin
            logic [7:0] exp_d;
            exp_d = use_g ? pat_g(i) : pat_f(i);
            chk({req, " mem_req"}, {31'b0, mem_req}, 32'd1);
            chk({req, " mem_we"}, {31'b0, mem_we}, {31'b0, exp_we});
            chk({req, " mem_addr"}, mem_addr, BASE + 32'(i));
            if (exp_we) chk({req, " mem_wdata"}, {24'b0, mem_wdata}, {24'b0, exp_d});
            if (i % 4 == 1) begin
                @(negedge clk);
                chk("R11 mem_addr held while waiting", mem_addr, BASE + 32'(i));
                if (exp_we) chk("R11 mem_wdata held", {24'b0, mem_wdata}, {24'b0, exp_d});
            end
            mem_ack   = 1'b1;
            mem_err   = (i == err_at);
            mem_rdata = pat_g(i);
            @(negedge clk);
            mem_ack = 1'b0;
            mem_err = 1'b0;
            if (i == err_at) return;
        end
        chk_sta({req, " done not yet set"}, sta_before);
        @(negedge clk);
        chk_sta({req, " memory done one cycle later"}, sta_before | 8'h02);
    endtask

    // buffer-to-flash phase: stall every byte with i%3==0
    task automatic drain_flash(input logic [7:0] sta_before);
        for (int i = 0; i < PAGE; i++) begin
            if (i % 3 == 0) begin
                fl_out_ready = 1'b0;
                @(negedge clk);
            end
            chk("R5 fl_out_valid", {31'b0, fl_out_valid}, 32'd1);
            chk("R5 fl_out_data", {24'b0, fl_out_data}, {24'b0, pat_g(i)});
            fl_out_ready = 1'b1;
            @(negedge clk);
        end
        fl_out_ready = 1'b0;
        chk_sta("R5 done not yet set", sta_before);
        @(negedge clk);
        chk_sta("R5 internal done one cycle later", sta_before | 8'h01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        foreach (v[k]) begin end
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk("R1 register zero after reset", {24'b0, v}, 32'd0);
        end
        chk("R1 irq low", {31'b0, irq}, 32'd0);
        chk("R1 mem_req low", {31'b0, mem_req}, 32'd0);
        chk("R1 fl_in_ready low", {31'b0, fl_in_ready}, 32'd0);
        chk("R1 fl_out_valid low", {31'b0, fl_out_valid}, 32'd0);

        // R10 little-endian base
        for (int k = 0; k < 4; k++) wr(4'(4 + k), BASE[k*8 +: 8]);
        for (int k = 0; k < 4; k++) begin
            rd(4'(4 + k), v);
            chk("R10 base byte readback", {24'b0, v}, {24'b0, BASE[k*8 +: 8]});
        end

        // page read: internal then memory phase
        wr(4'h0, 8'h03);
        feed_flash(8'h00);
        wr(4'h0, 8'h05);
        serve_mem("R3", 1'b1, 1'b0, -1, 8'h01);

        // R7 exhaustive enable sweep with status 0b011
        for (int e = 0; e < 8; e++) begin
            wr(4'h8, 8'(e));
            chk("R7 irq vs status and enable", {31'b0, irq}, {31'b0, ((e & 3) != 0)});
        end

        // R6 write-one-to-clear
        wr(4'hC, 8'h00);
        chk_sta("R6 zero write keeps bits", 8'h03);
        wr(4'hC, 8'h01);
        chk_sta("R6 clear bit0 only", 8'h02);
        wr(4'hC, 8'h02);
        chk_sta("R6 clear bit1", 8'h00);
        chk("R7 irq low when status clear", {31'b0, irq}, 32'd0);

        // page write: memory then internal phase
        wr(4'h0, 8'h04);
        serve_mem("R4", 1'b0, 1'b1, -1, 8'h00);
        wr(4'h0, 8'h02);
        drain_flash(8'h02);
        wr(4'hC, 8'h07);
        chk_sta("R6 clear all", 8'h00);

        // R8 memory error on byte 5 (buffer holds pat_g)
        wr(4'h0, 8'h05);
        serve_mem("R8", 1'b1, 1'b1, 5, 8'h00);
        chk_sta("R8 error bit only", 8'h04);
        chk("R8 mem_req dropped", {31'b0, mem_req}, 32'd0);
        chk("R7 irq from error bit", {31'b0, irq}, 32'd1);
        repeat (4) @(negedge clk);
        chk_sta("R8 no done after abort", 8'h04);
        wr(4'hC, 8'h04);

        // R9 stop mid-phase
        wr(4'h0, 8'h03);
        for (int i = 0; i < 3; i++) begin
            fl_in_valid = 1'b1; fl_in_data = 8'hA5;
            @(negedge clk);
        end
        fl_in_valid = 1'b0;
        wr(4'h0, 8'h00);
        chk("R9 fl_in_ready low after stop", {31'b0, fl_in_ready}, 32'd0);
        repeat (5) @(negedge clk);
        chk_sta("R9 no status after stop", 8'h00);
        wr(4'h0, 8'h07);
        chk("R9 both selects: no mem_req", {31'b0, mem_req}, 32'd0);
        chk("R9 both selects: no fl_in_ready", {31'b0, fl_in_ready}, 32'd0);
        chk("R9 both selects: no fl_out_valid", {31'b0, fl_out_valid}, 32'd0);
        repeat (5) @(negedge clk);
        chk_sta("R9 both selects: no status", 8'h00);
        wr(4'h8, 8'h00);
        chk("R7 irq masked", {31'b0, irq}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule